// File: doc/BRIEF.md
# Streaming Byte Run-Length Encoder

The encoder takes a byte stream, qualified by a valid strobe, and folds each run of equal consecutive bytes into a single 16-bit word. The high byte of the word holds how many times the value repeated. The low byte holds the value itself. The block accepts one byte on every cycle where the strobe is high. It has no way to stall the source and no way to be stalled by the sink.

A run closes in three cases:

- the next byte has a different value;
- the count reaches 255;
- the source flags a byte as the last of the stream.

The final word of a stream carries an end marker. Afterwards the block starts the next stream from a clean state.

Outputs are registered, so a word appears one cycle after the byte that closed its run. One case needs two words from a single input byte: the flagged last byte differs from the run in progress. The closed run is output first. The single-byte final run follows one cycle later.

Top module: `rle_encoder`

## Requirements
- R1: Every emitted word carries the run length in bits [15:8] and the byte value in bits [7:0]; the length is never zero.
- R2: A valid byte whose value differs from the open run emits that run with the end marker low, and starts a new run of length 1 with the new byte.
- R3: A matching valid byte that raises the count to 255 emits {255, value} for that byte. The next matching byte opens a fresh run of length 1.
- R4: A flagged last byte that matches the open run emits that run, with this byte counted, and with the end marker high.
- R5: A flagged last byte that differs from the open run emits the old run with the marker low. One cycle later it emits {1, new byte} with the marker high.
- R6: A flagged last byte that arrives with no run open emits {1, byte} with the marker high.
- R7: out_valid is high only on cycles that carry a word. out_last is high only on a stream's final word and never while out_valid is low.
- R8: On cycles with in_valid low, in_data and in_last have no effect and the open run and its count are kept.
- R9: A synchronous active-high reset clears every run and every pending word, and drives out_valid, out_last and out_data to zero.
- R10: A valid byte that arrives on the cycle the deferred final word is output opens a new run of length 1. It is neither lost nor merged.
- R11: A word caused by the input of cycle N appears at the outputs in cycle N+1.
- R12: After a stream's final word, the next valid byte opens a new run whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The byte on in_data is presented this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | The presented byte ends the stream |
| out_valid | output | 1 | An encoded word is on out_data |
| out_data | output | 16 | {run length, byte value} |
| out_last | output | 1 | The word on out_data ends the stream |

## Verification
The assertions assume that reset is high on the first edge. They also assume that in_data and in_last are defined whenever in_valid is high. Beyond that, they allow any valid pattern, including a new byte on the very cycle a deferred final word is output.

The stimulus holds reset from time zero and always drives defined values. During invalid cycles it puts random data and random last flags on the input, so that ignoring them is actually tested. Bytes come from a four-value alphabet with a small chance of a last flag, which keeps runs short and value changes frequent. Directed streams of long equal runs reach the 255 limit, including a last flag placed exactly on the 255th byte.

// File: rtl/rle_encoder.sv
module rle_encoder #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [DW-1:0]      in_data,
  input  logic               in_last,
  output logic               out_valid,
  output logic [CW+DW-1:0]   out_data,
  output logic               out_last
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          act, pend;
  logic [DW-1:0] val, pval;
  logic [CW-1:0] cnt;

  wire           same = act && (in_data == val);
  wire [CW-1:0]  nxt  = cnt + ONE;
  wire           sat  = (nxt == CMAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b0;
      pend      <= 1'b0;
      val       <= '0;
      pval      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (pend) begin
        out_valid <= 1'b1;
        out_last  <= 1'b1;
        out_data  <= {ONE, pval};
        pend      <= 1'b0;
        if (in_valid) begin
          if (in_last) begin
            pend <= 1'b1;
            pval <= in_data;
            act  <= 1'b0;
          end else begin
            act <= 1'b1;
            val <= in_data;
            cnt <= ONE;
          end
        end
      end else if (in_valid) begin
        if (!act) begin
          if (in_last) begin
            out_valid <= 1'b1;
            out_last  <= 1'b1;
            out_data  <= {ONE, in_data};
          end else begin
            act <= 1'b1;
            val <= in_data;
            cnt <= ONE;
          end
        end else if (same) begin
          if (sat || in_last) begin
            out_valid <= 1'b1;
            out_last  <= in_last;
            out_data  <= {nxt, val};
            act       <= 1'b0;
          end else begin
            cnt <= nxt;
          end
        end else begin
          out_valid <= 1'b1;
          out_data  <= {cnt, val};
          if (in_last) begin
            pend <= 1'b1;
            pval <= in_data;
            act  <= 1'b0;
          end else begin
            val <= in_data;
            cnt <= ONE;
          end
        end
      end
    end
  end
endmodule

module rle_encoder_chk #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [DW-1:0]    in_data,
  input logic             in_last,
  input logic             out_valid,
  input logic [CW+DW-1:0] out_data,
  input logic             out_last,
  input logic             act,
  input logic             pend,
  input logic [DW-1:0]    val
);
  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_last && out_data == '0));

  p_last_with_valid_r7: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  p_len_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[CW+DW-1:DW] != '0));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !pend) |=> !out_valid);

  p_deferred_word_r5: assert property (@(posedge clk) disable iff (rst)
    pend |=> (out_valid && out_last && out_data[CW+DW-1:DW] == CW'(1)));

  p_change_emits_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && act && !pend && in_data != val)
      |=> (out_valid && !out_last && out_data[DW-1:0] == $past(val)));

  p_fresh_after_defer_r10: assert property (@(posedge clk) disable iff (rst)
    (pend && in_valid && !in_last) |=> act);
endmodule

bind rle_encoder rle_encoder_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
  .out_last(out_last), .act(act), .pend(pend), .val(val)
);

// File: tb/test_rle_encoder.sv
module test_rle_encoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_last;

  always #2 clk = ~clk;

  rle_encoder i_rle_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  bit         m_act, m_pend;
  logic [7:0] m_val, m_pval;
  int         m_cnt;
  bit         exp_v, exp_l;
  logic [15:0] exp_d;
  string      exp_tag;

  task automatic model(bit v, logic [7:0] d, bit l);
    exp_v = 0; exp_l = 0; exp_tag = "R7";
    if (m_pend) begin
      exp_v = 1; exp_l = 1; exp_d = {8'd1, m_pval}; exp_tag = "R5"; m_pend = 0;
      if (v) begin
        exp_tag = "R10";
        if (l) begin m_pend = 1; m_pval = d; m_act = 0; end
        else begin m_act = 1; m_val = d; m_cnt = 1; end
      end
    end else if (v) begin
      if (!m_act) begin
        if (l) begin exp_v = 1; exp_l = 1; exp_d = {8'd1, d}; exp_tag = "R6"; end
        else begin m_act = 1; m_val = d; m_cnt = 1; exp_tag = "R12"; end
      end else if (d == m_val) begin
        m_cnt++;
        if (m_cnt == 255 || l) begin
          exp_v = 1; exp_l = l; exp_d = {8'(m_cnt), m_val};
          exp_tag = (m_cnt == 255) ? "R3" : "R4";
          m_act = 0;
        end else exp_tag = "R11";
      end else begin
        exp_v = 1; exp_d = {8'(m_cnt), m_val}; exp_tag = "R2";
        if (l) begin m_pend = 1; m_pval = d; m_act = 0; end
        else begin m_val = d; m_cnt = 1; end
      end
    end else exp_tag = "R8";
  endtask

  task automatic check();
    total++;
    if (out_valid !== exp_v || out_last !== exp_l || (exp_v && out_data !== exp_d)) begin
      bad++;
      $display("FAIL %s/R1 valid=%0b last=%0b data=%h expected valid=%0b last=%0b data=%h",
               exp_tag, out_valid, out_last, out_data, exp_v, exp_l, exp_d);
    end
  endtask

  task automatic step(bit v, logic [7:0] d, bit l);
    in_valid = v;
    in_data  = v ? d : 8'($urandom);
    in_last  = v ? l : 1'($urandom);
    model(v, d, l);
    @(negedge clk);
    check();
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 1; in_data = 8'($urandom); in_last = 0;
    @(negedge clk); @(negedge clk);
    total++;
    if (out_valid !== 0 || out_last !== 0 || out_data !== 16'h0) begin
      bad++;
      $display("FAIL R9 valid=%0b last=%0b data=%h expected 0 0 0000", out_valid, out_last, out_data);
    end
    rst = 0; in_valid = 0;
    m_act = 0; m_pend = 0; m_cnt = 0; exp_v = 0; exp_l = 0; exp_d = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R3, R4: 300 equal bytes then last -> {255,A5}, then {45,A5} last
    for (int i = 0; i < 299; i++) step(1, 8'hA5, 0);
    step(1, 8'hA5, 1);
    step(0, 0, 0);
    // 255th byte flagged last -> single {255,3C} with last
    for (int i = 0; i < 254; i++) step(1, 8'h3C, 0);
    step(1, 8'h3C, 1);
    step(0, 0, 0);
    // R6 lone last byte, R12 new stream same value
    step(1, 8'h11, 1);
    step(1, 8'h11, 0);
    // R8 gaps with garbage
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    step(1, 8'h11, 0);
    // R5 differing last, R10 byte on deferred cycle
    step(1, 8'h22, 1);
    step(1, 8'h33, 0);
    step(1, 8'h33, 1);
    // deferred cycle with last byte again
    step(1, 8'h44, 0);
    step(1, 8'h55, 1);
    step(1, 8'h66, 1);
    step(0, 0, 0);
    step(0, 0, 0);
    // R9 mid-stream reset
    step(1, 8'h77, 0);
    step(1, 8'h77, 0);
    do_reset();
    step(1, 8'h77, 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom % 10) < 7;
      step(v, 8'($urandom % 4), ($urandom % 20) == 0);
    end
    step(0, 0, 0);
    step(0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule